// File: doc/BRIEF.md
# Instruction Fetch Address Translation Checker

This block sits between the fetch unit and an external translation lookaside buffer. For each fetch request it takes the virtual address and a packed machine-state word. From these it decides whether translation is bypassed or a buffer lookup is needed. It then drives the lookup key, judges the buffer's answer and returns one result. That result is either a physical address or exactly one fault code. Faults are ranked in a fixed order: misalignment first, then the address hole, then a miss, then a privilege breach. A misalignment, hole or privilege fault also yields a new fault-status register value, which records overflow when an earlier fault was still pending. A miss instead yields a new tag-access register value for the refill handler.

The buffer array is outside the block. It answers combinationally on a small port: a hit flag, a physical page number and a privileged-page flag. The result is registered and appears one clock edge after the request is sampled.

Top module: `ifetch_xlat_check`

## Requirements
- R1: When state bit 0 (hyperprivileged) or bit 1 (reset/error mode) is set, the request completes with respOk and respPaddr equal to the low PA_W bits of the virtual address. No lookup is issued, and neither misalignment nor the address hole faults.
- R2: With a nonzero trap level in state bits 18:16, the nucleus context is used: context 0, context type 2, ASI 0x04. Otherwise the context is taken from the low CTX_W bits of state bits 47:32, with context type 0 and ASI 0x80.
- R3: An untranslated request whose address has bit 1 or bit 0 set faults with code 1 (misaligned) and fault type 0x08. No lookup is issued, and this fault outranks every other fault.
- R4: When state bit 3 (address mask) is set, bits 63:32 of the address are cleared before lookup and the hole check is skipped.
- R5: When the address mask is clear and the address lies in [HOLE_LO, HOLE_HI], the request faults with code 2 (out of range) and fault type 0x20, with no lookup.
- R6: If state bit 4 (translation enable) is clear, the lookup is a real-address lookup with context 0. If it is set, the lookup is virtual with the R2 context. The partition field is taken from state bits 15:8.
- R7: On a miss, the request faults with code 4 for a real lookup or code 8 for a virtual lookup. tagWe is raised and tagNext holds the page-aligned address (low PAGE_BITS bits cleared) ORed with the lookup context. The fault status is not written.
- R8: A hit on a privileged page while state bit 2 (privileged) is clear faults with code 16 and fault type 0x01.
- R9: A clean hit returns respOk with respPaddr equal to the page number followed by the low PAGE_BITS address bits.
- R10: On each fault-status write: bit 0 is 1; bit 1 copies bit 0 of the current status; bits 2 and 6 are 0; bits 5:4 hold the context type; bits 15:7 hold the fault type; bits 23:16 hold the ASI. All other bits are 0.
- R11: Results are due one clock edge after a sampled request. A completed response carries exactly one of respOk or a single one-hot fault code. A cycle without a request yields no response.
- R12: After reset, respValid, respOk, respFault, fsrWe and tagWe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fetch request present |
| reqVaddr | input | 64 | Fetch virtual address |
| stateWord | input | 64 | Packed machine state |
| fsrCur | input | 64 | Current fault-status register value |
| tlbReqValid | output | 1 | Lookup issued this cycle |
| tlbVaddr | output | 64 | Lookup address after masking |
| tlbPartId | output | 8 | Lookup partition |
| tlbContext | output | CTX_W | Lookup context |
| tlbReal | output | 1 | Lookup is real-address |
| tlbHit | input | 1 | Buffer hit |
| tlbPpn | input | PA_W-PAGE_BITS | Physical page number on hit |
| tlbPriv | input | 1 | Hit page is privileged |
| respValid | output | 1 | Result present |
| respOk | output | 1 | Translation succeeded |
| respPaddr | output | PA_W | Physical address |
| respFault | output | 5 | One-hot fault code |
| fsrWe | output | 1 | Write fault status |
| fsrNext | output | 64 | New fault-status value |
| tagWe | output | 1 | Write tag access |
| tagNext | output | 64 | New tag-access value |

## Verification
The lookup key is combinational from the request, so the bench checks tlbReqValid, tlbReal, tlbContext and tlbVaddr shortly after driving each request in the same cycle. Every registered result (respValid, respOk, respPaddr, respFault and both register updates) is due at the next rising edge. The bench therefore computes the expected bundle when it drives a request and compares it at the following falling edge, just before driving the next one. Idle cycles are compared the same way, which covers the no-response case.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

  typedef enum logic [4:0] {
    FLT_NONE     = 5'd0,
    FLT_MISALIGN = 5'd1,
    FLT_RANGE    = 5'd2,
    FLT_RMISS    = 5'd4,
    FLT_VMISS    = 5'd8,
    FLT_PRIV     = 5'd16
  } fault_e;

  localparam int SW_HPRIV  = 0;
  localparam int SW_RED    = 1;
  localparam int SW_PRIV   = 2;
  localparam int SW_AMASK  = 3;
  localparam int SW_XLATEN = 4;
  localparam int SW_PART_LO = 8;
  localparam int SW_TL_LO   = 16;
  localparam int SW_CTX_LO  = 32;

  localparam logic [1:0] CT_PRIMARY = 2'd0;
  localparam logic [1:0] CT_NUCLEUS = 2'd2;
  localparam logic [7:0] ASI_PRIMARY = 8'h80;
  localparam logic [7:0] ASI_NUCLEUS = 8'h04;

  localparam logic [8:0] FT_PRIV     = 9'h001;
  localparam logic [8:0] FT_MISALIGN = 9'h008;
  localparam logic [8:0] FT_RANGE    = 9'h020;

  typedef struct packed {
    logic       lookup;
    logic       ok;
    logic       bypass;
    logic       fsrWrite;
    logic       tagWrite;
    fault_e     fault;
    logic [8:0] ftype;
  } ifx_strobe_t;

endpackage

// File: rtl/ifx_ctrl.sv
module ifx_ctrl
  import ifx_pkg::*;
(
  input  logic        reqValid,
  input  logic        hpriv,
  input  logic        red,
  input  logic        priv,
  input  logic        amask,
  input  logic        misaligned,
  input  logic        inHole,
  input  logic        lookupReal,
  input  logic        tlbHit,
  input  logic        tlbPriv,
  output ifx_strobe_t st
);

  always_comb begin
    st = '{lookup: 1'b0, ok: 1'b0, bypass: 1'b0, fsrWrite: 1'b0,
           tagWrite: 1'b0, fault: FLT_NONE, ftype: 9'h0};
    if (reqValid) begin
      if (hpriv || red) begin
        st.bypass = 1'b1;
        st.ok     = 1'b1;
      end else if (misaligned) begin
        st.fault    = FLT_MISALIGN;
        st.ftype    = FT_MISALIGN;
        st.fsrWrite = 1'b1;
      end else if (!amask && inHole) begin
        st.fault    = FLT_RANGE;
        st.ftype    = FT_RANGE;
        st.fsrWrite = 1'b1;
      end else begin
        st.lookup = 1'b1;
        if (!tlbHit) begin
          st.fault    = lookupReal ? FLT_RMISS : FLT_VMISS;
          st.tagWrite = 1'b1;
        end else if (tlbPriv && !priv) begin
          st.fault    = FLT_PRIV;
          st.ftype    = FT_PRIV;
          st.fsrWrite = 1'b1;
        end else begin
          st.ok = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ifx_dp.sv
module ifx_dp
  import ifx_pkg::*;
#(
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 13,
  parameter int CTX_W     = 13,
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF,
  localparam int PPN_W = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqVaddr,
  input  logic [63:0]       stateWord,
  input  logic [63:0]       fsrCur,
  input  ifx_strobe_t       st,
  output logic              misaligned,
  output logic              inHole,
  output logic              lookupReal,
  output logic              tlbReqValid,
  output logic [63:0]       tlbVaddr,
  output logic [7:0]        tlbPartId,
  output logic [CTX_W-1:0]  tlbContext,
  output logic              tlbReal,
  input  logic [PPN_W-1:0]  tlbPpn,
  output logic              respValid,
  output logic              respOk,
  output logic [PA_W-1:0]   respPaddr,
  output logic [4:0]        respFault,
  output logic              fsrWe,
  output logic [63:0]       fsrNext,
  output logic              tagWe,
  output logic [63:0]       tagNext
);

  logic [63:0]      effVa;
  logic             useNucleus;
  logic [CTX_W-1:0] selCtx, keyCtx;
  logic [1:0]       ctxType;
  logic [7:0]       asiVal;
  logic [63:0]      fsrBuild, tagBuild;
  logic [PA_W-1:0]  paBuild;
  logic             unusedBits;

  assign unusedBits = ^{stateWord, fsrCur};

  assign effVa      = stateWord[SW_AMASK] ? {32'h0, reqVaddr[31:0]} : reqVaddr;
  assign misaligned = |reqVaddr[1:0];
  assign inHole     = (effVa >= HOLE_LO) && (effVa <= HOLE_HI);
  assign useNucleus = |stateWord[SW_TL_LO +: 3];
  assign selCtx     = useNucleus ? '0 : stateWord[SW_CTX_LO +: CTX_W];
  assign lookupReal = !stateWord[SW_XLATEN];
  assign keyCtx     = lookupReal ? '0 : selCtx;
  assign ctxType    = useNucleus ? CT_NUCLEUS : CT_PRIMARY;
  assign asiVal     = useNucleus ? ASI_NUCLEUS : ASI_PRIMARY;

  assign tlbReqValid = st.lookup;
  assign tlbVaddr    = effVa;
  assign tlbPartId   = stateWord[SW_PART_LO +: 8];
  assign tlbContext  = keyCtx;
  assign tlbReal     = lookupReal;

  always_comb begin
    fsrBuild        = '0;
    fsrBuild[0]     = 1'b1;
    fsrBuild[1]     = fsrCur[0];
    fsrBuild[5:4]   = ctxType;
    fsrBuild[15:7]  = st.ftype;
    fsrBuild[23:16] = asiVal;
  end

  assign tagBuild = {effVa[63:PAGE_BITS], {PAGE_BITS{1'b0}}}
                  | {{(64-CTX_W){1'b0}}, keyCtx};
  assign paBuild  = st.bypass ? reqVaddr[PA_W-1:0]
                              : {tlbPpn, effVa[PAGE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respOk    <= 1'b0;
      respPaddr <= '0;
      respFault <= '0;
      fsrWe     <= 1'b0;
      fsrNext   <= '0;
      tagWe     <= 1'b0;
      tagNext   <= '0;
    end else begin
      respValid <= st.ok || (st.fault != FLT_NONE);
      respOk    <= st.ok;
      respPaddr <= st.ok ? paBuild : '0;
      respFault <= st.fault;
      fsrWe     <= st.fsrWrite;
      fsrNext   <= st.fsrWrite ? fsrBuild : '0;
      tagWe     <= st.tagWrite;
      tagNext   <= st.tagWrite ? tagBuild : '0;
    end
  end

  a_r11_one_result: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({respOk, respFault}) == 1));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  a_r1_bypass_ok: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (stateWord[SW_HPRIV] || stateWord[SW_RED]) |=> respValid && respOk);

  a_r3_aligned_key: assert property (@(posedge clk) disable iff (!rstN)
    tlbReqValid |-> (reqVaddr[1:0] == 2'b00));

  a_r10_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fsrWe |-> fsrNext[0] && (fsrNext[1] == $past(fsrCur[0])));

  a_r7_tag_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    tagWe |-> (respFault == FLT_RMISS || respFault == FLT_VMISS));

endmodule

// File: rtl/ifetch_xlat_check.sv
module ifetch_xlat_check
  import ifx_pkg::*;
#(
  parameter int PA_W      = 40,
  parameter int PAGE_BITS = 13,
  parameter int CTX_W     = 13,
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF,
  localparam int PPN_W = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqVaddr,
  input  logic [63:0]       stateWord,
  input  logic [63:0]       fsrCur,
  output logic              tlbReqValid,
  output logic [63:0]       tlbVaddr,
  output logic [7:0]        tlbPartId,
  output logic [CTX_W-1:0]  tlbContext,
  output logic              tlbReal,
  input  logic              tlbHit,
  input  logic [PPN_W-1:0]  tlbPpn,
  input  logic              tlbPriv,
  output logic              respValid,
  output logic              respOk,
  output logic [PA_W-1:0]   respPaddr,
  output logic [4:0]        respFault,
  output logic              fsrWe,
  output logic [63:0]       fsrNext,
  output logic              tagWe,
  output logic [63:0]       tagNext
);

  ifx_strobe_t st;
  logic misaligned, inHole, lookupReal;

  ifx_ctrl i_ctrl (
    .reqValid  (reqValid),
    .hpriv     (stateWord[SW_HPRIV]),
    .red       (stateWord[SW_RED]),
    .priv      (stateWord[SW_PRIV]),
    .amask     (stateWord[SW_AMASK]),
    .misaligned(misaligned),
    .inHole    (inHole),
    .lookupReal(lookupReal),
    .tlbHit    (tlbHit),
    .tlbPriv   (tlbPriv),
    .st        (st)
  );

  ifx_dp #(
    .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .CTX_W(CTX_W),
    .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) i_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .stateWord(stateWord), .fsrCur(fsrCur), .st(st),
    .misaligned(misaligned), .inHole(inHole), .lookupReal(lookupReal),
    .tlbReqValid(tlbReqValid), .tlbVaddr(tlbVaddr), .tlbPartId(tlbPartId),
    .tlbContext(tlbContext), .tlbReal(tlbReal), .tlbPpn(tlbPpn),
    .respValid(respValid), .respOk(respOk), .respPaddr(respPaddr),
    .respFault(respFault), .fsrWe(fsrWe), .fsrNext(fsrNext),
    .tagWe(tagWe), .tagNext(tagNext)
  );

endmodule

// File: tb/test_ifetch_xlat_check.sv
module test_ifetch_xlat_check;
  localparam int PA_W = 40, PAGE_BITS = 13, CTX_W = 13, PPN_W = PA_W - PAGE_BITS;
  localparam logic [63:0] HLO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] HHI = 64'hFFFF_7FFF_FFFF_FFFF;

  logic clk = 0, rstN = 0, reqValid = 0;
  logic [63:0] reqVaddr = 0, stateWord = 0, fsrCur = 0;
  logic tlbReqValid, tlbReal, tlbHit, tlbPriv;
  logic [63:0] tlbVaddr;
  logic [7:0] tlbPartId;
  logic [CTX_W-1:0] tlbContext;
  logic [PPN_W-1:0] tlbPpn;
  logic respValid, respOk, fsrWe, tagWe;
  logic [PA_W-1:0] respPaddr;
  logic [4:0] respFault;
  logic [63:0] fsrNext, tagNext;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ifetch_xlat_check i_ifetch_xlat_check (.*);

  // Bench-side buffer contents
  function automatic void tlbModel(input logic [63:0] va, input logic isReal,
      input logic [CTX_W-1:0] ctx, input logic [7:0] part,
      output logic hit, output logic [PPN_W-1:0] ppn, output logic pv);
    logic [63:0] pg;
    pg = va >> PAGE_BITS;
    hit = 0; ppn = '0; pv = 0;
    if (part == 8'd3) begin
      if (!isReal && ctx == 5 && pg == (64'h400000 >> PAGE_BITS)) begin hit = 1; ppn = 'h123; end
      if (!isReal && ctx == 5 && pg == (64'h600000 >> PAGE_BITS)) begin hit = 1; ppn = 'h456; pv = 1; end
      if ( isReal && pg == (64'h100000 >> PAGE_BITS)) begin hit = 1; ppn = 'h789; end
      if (!isReal && ctx == 0 && pg == (64'h800000 >> PAGE_BITS)) begin hit = 1; ppn = 'hABC; end
    end
  endfunction

  always_comb tlbModel(tlbVaddr, tlbReal, tlbContext, tlbPartId, tlbHit, tlbPpn, tlbPriv);

  // expected values
  logic eValid, eOk, eFsrWe, eTagWe, eLook, eReal;
  logic [PA_W-1:0] ePa;
  logic [4:0] eFault;
  logic [63:0] eFsr, eTag, eKeyVa;
  logic [CTX_W-1:0] eCtx;
  string eTagName;
  bit pending = 0;

  function automatic logic [63:0] mkSw(bit hp, bit rd, bit pv, bit am, bit en,
      int part, int tl, int ctx);
    return 64'(hp) | (64'(rd) << 1) | (64'(pv) << 2) | (64'(am) << 3) | (64'(en) << 4)
         | (64'(part) << 8) | (64'(tl) << 16) | (64'(ctx) << 32);
  endfunction

  task automatic model(input logic v, input logic [63:0] va, input logic [63:0] sw,
                       input logic [63:0] fc);
    logic [63:0] ea;
    logic nuc, h, p;
    logic [PPN_W-1:0] n;
    logic [1:0] ct;
    logic [7:0] asi;
    logic [8:0] ft;
    eValid = 0; eOk = 0; ePa = 0; eFault = 0; eFsrWe = 0; eTagWe = 0;
    eFsr = 0; eTag = 0; eLook = 0; eReal = 0; eCtx = 0; ft = 0;
    ea = sw[3] ? (va & 64'hFFFF_FFFF) : va;
    nuc = sw[18:16] != 0;
    ct = nuc ? 2 : 0;
    asi = nuc ? 8'h04 : 8'h80;
    eKeyVa = ea;
    if (!v) return;
    eValid = 1;
    if (sw[0] || sw[1]) begin eOk = 1; ePa = va[PA_W-1:0]; end
    else if (va[1:0] != 0) begin eFault = 1; ft = 9'h08; end
    else if (!sw[3] && ea >= HLO && ea <= HHI) begin eFault = 2; ft = 9'h20; end
    else begin
      eLook = 1;
      eReal = !sw[4];
      eCtx = (eReal || nuc) ? '0 : sw[32 +: CTX_W];
      tlbModel(ea, eReal, eCtx, sw[15:8], h, n, p);
      if (!h) begin
        eFault = eReal ? 4 : 8; eTagWe = 1;
        eTag = (ea & ~64'h1FFF) | 64'(eCtx);
      end else if (p && !sw[2]) begin eFault = 16; ft = 9'h01; end
      else begin eOk = 1; ePa = {n, ea[PAGE_BITS-1:0]}; end
    end
    if (ft != 0) begin
      eFsrWe = 1;
      eFsr = 64'h1 | (fc[0] ? 64'h2 : 0) | (64'(ct) << 4) | (64'(ft) << 7) | (64'(asi) << 16);
    end
  endtask

  task automatic compareOut();
    checks++;
    if (respValid !== eValid || respFault !== eFault || respOk !== eOk ||
        (eOk && respPaddr !== ePa) || fsrWe !== eFsrWe || (eFsrWe && fsrNext !== eFsr) ||
        tagWe !== eTagWe || (eTagWe && tagNext !== eTag)) begin
      fails++;
      $display("FAIL %s: got v=%b ok=%b pa=%h f=%0d fw=%b fsr=%h tw=%b tag=%h exp v=%b ok=%b pa=%h f=%0d fw=%b fsr=%h tw=%b tag=%h",
        eTagName, respValid, respOk, respPaddr, respFault, fsrWe, fsrNext, tagWe, tagNext,
        eValid, eOk, ePa, eFault, eFsrWe, eFsr, eTagWe, eTag);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] va, input logic [63:0] sw,
                      input logic [63:0] fc, input string tg);
    @(negedge clk);
    if (pending) compareOut();
    reqValid = v; reqVaddr = va; stateWord = sw; fsrCur = fc;
    model(v, va, sw, fc);
    eTagName = tg;
    pending = 1;
    #1;
    checks++;
    if (tlbReqValid !== eLook || (eLook && (tlbReal !== eReal || tlbContext !== eCtx ||
        tlbVaddr !== eKeyVa || tlbPartId !== sw[15:8]))) begin
      fails++;
      $display("FAIL %s key: got look=%b real=%b ctx=%h va=%h exp look=%b real=%b ctx=%h va=%h",
        tg, tlbReqValid, tlbReal, tlbContext, tlbVaddr, eLook, eReal, eCtx, eKeyVa);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R12 reset state
    if (respValid !== 0 || respOk !== 0 || respFault !== 0 || fsrWe !== 0 || tagWe !== 0) begin
      fails++;
      $display("FAIL R12: got v=%b ok=%b f=%0d fw=%b tw=%b exp all 0",
               respValid, respOk, respFault, fsrWe, tagWe);
    end
    rstN = 1;
    step(1, 64'h0000_1234_5678_9ABF, mkSw(1,0,0,0,1,3,0,5), 0, "R1 hpriv bypass misaligned");
    step(1, 64'h8000_0000_0000_0000, mkSw(0,1,0,0,1,3,0,5), 0, "R1 red bypass in hole");
    step(1, 64'h0000_0000_0040_0002, mkSw(0,0,0,0,1,3,0,5), 0, "R3 misaligned primary");
    step(1, 64'h0000_8000_0000_0001, mkSw(0,0,0,0,1,3,1,5), 64'h1, "R3 R10 priority overflow nucleus");
    step(1, 64'h0000_8000_0000_0000, mkSw(0,0,0,0,1,3,0,5), 0, "R5 hole");
    step(1, 64'hFFFF_7FFF_FFFF_FFFC, mkSw(0,0,0,0,1,3,2,5), 64'h3, "R5 R2 hole top nucleus");
    step(1, 64'h0000_8000_0000_0000, mkSw(0,0,0,1,1,3,0,5), 0, "R4 mask skips hole miss");
    step(1, 64'h0000_0000_0040_0004, mkSw(0,0,0,0,1,3,0,5), 0, "R9 virtual hit");
    step(1, 64'hFFFF_FFFF_0040_0008, mkSw(0,0,0,1,1,3,0,5), 0, "R4 masked hit");
    step(1, 64'h0000_0000_0010_0010, mkSw(0,0,0,0,0,3,0,5), 0, "R6 real hit");
    step(1, 64'h0000_0000_0040_0000, mkSw(0,0,0,0,0,3,0,5), 0, "R7 real miss");
    step(1, 64'h0000_0000_0123_4564, mkSw(0,0,0,0,1,3,0,5), 0, "R7 virtual miss tag");
    step(1, 64'h0000_0000_0060_0000, mkSw(0,0,0,0,1,3,0,5), 0, "R8 priv violation");
    step(1, 64'h0000_0000_0060_0000, mkSw(0,0,1,0,1,3,0,5), 64'h1, "R8 priv mode ok");
    step(1, 64'h0000_0000_0080_0010, mkSw(0,0,0,0,1,3,1,5), 0, "R2 nucleus hit");
    step(1, 64'h0000_0000_0040_0000, mkSw(0,0,0,0,1,3,1,5), 0, "R2 nucleus miss ctx0");
    step(1, 64'h0000_0000_0040_0000, mkSw(0,0,0,0,1,2,0,5), 0, "R6 partition mismatch");
    step(0, 64'h0000_0000_0040_0000, mkSw(0,0,0,0,1,3,0,5), 0, "R11 idle");
    step(1, 64'h0000_0000_0040_0000, mkSw(0,0,0,0,1,3,0,5), 0, "R11 back to back");
    step(0, 0, 0, 0, "R11 idle end");
    @(negedge clk);
    compareOut();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule